// File: doc/BRIEF.md
# Pipeline hazard stall unit

This block decides, in the same cycle, whether the instruction sitting in the decode stage of a scalar in-order five-stage pipeline may move on into execute. It sees the decoded register fields and operation class of the decode and execute stage registers. It also sees the destination fields of the early stages of a four-stage pipelined multiplier. That multiplier runs beside execute and memory, and its final stage shares the single register-file write port with the main pipe.

The decision has no internal state. The block is re-evaluated every cycle from whatever the stage registers hold, so a dependence that lasts several cycles gives back-to-back bubbles. When the unit stalls, the pipeline control holds the program counter and the decode latch and turns the execute latch into a nop with cleared controls. Each hazard term is also brought out on its own pin, so that a bench or a performance counter can see which cause fired.

Top module: `hazard_stall_unit`

## Requirements
- R1: Operation classes are coded on two bits: 0 other, 1 load, 2 store, 3 multiply. `hz_load_use` is raised when the execute instruction is a load and its destination matches the decode instruction's first source.
- R2: A match between the load destination and the decode second source also raises `hz_load_use`, except when the decode instruction is a store. In that case only the first source is considered.
- R3: `hz_mul_operand` is raised when either decode source matches the destination held in multiplier stage 0, 1 or 2. Stage k occupies bits `[k*REG_W +: REG_W]` of `mul_dst` and bit k of `mul_dst_vld`. Stage 3 is not observed.
- R4: `hz_wb_port` is raised when the decode instruction is not a multiply and writes a register while multiplier stage 1 holds a register-writing instruction. An instruction writes a register when its destination valid flag is set and its destination is not 0.
- R5: `hz_waw` is raised when the execute instruction is a multiply and its destination matches the decode destination.
- R6: While `stall` is 1, `pc_we` and `dec_latch_we` are 0 and `ex_bubble` is 1. While `stall` is 0, the two enables are 1 and `ex_bubble` is 0.
- R7: The outputs depend only on the present inputs. A dependence that persists over several cycles stalls in each of those cycles, and the stall ends in the first cycle the condition is gone.
- R8: A "match" requires both fields valid and equal and the register number not 0. Register 0, or a field whose valid flag is clear, never raises a hazard.
- R9: `stall` is the OR of the four hazard outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src1 | input | REG_W | Decode first source register |
| dec_src1_vld | input | 1 | Decode first source in use |
| dec_src2 | input | REG_W | Decode second source register |
| dec_src2_vld | input | 1 | Decode second source in use |
| dec_dst | input | REG_W | Decode destination register |
| dec_dst_vld | input | 1 | Decode destination in use |
| dec_op | input | 2 | Decode operation class |
| ex_dst | input | REG_W | Execute destination register |
| ex_dst_vld | input | 1 | Execute destination in use |
| ex_op | input | 2 | Execute operation class |
| mul_dst | input | MUL_STAGES*REG_W | Multiplier stage 0..2 destinations, packed |
| mul_dst_vld | input | MUL_STAGES | Multiplier stage destination valid flags |
| stall | output | 1 | Hold decode this cycle |
| pc_we | output | 1 | Program counter write enable |
| dec_latch_we | output | 1 | Decode latch write enable |
| ex_bubble | output | 1 | Load a nop with cleared controls into execute |
| hz_load_use | output | 1 | Load-use term |
| hz_mul_operand | output | 1 | Operand dependence on the multiplier term |
| hz_wb_port | output | 1 | Shared write-port collision term |
| hz_waw | output | 1 | Write-after-write behind a multiply term |

## Verification
The block is purely combinational, so a fault shows on the pins in the same cycle as the input pattern that exposes it. There is no hidden state that could delay the symptom. A wrong comparator, a missing store exemption or an off-by-one stage index shows as a hazard pin that disagrees with the bench model, and the same error shows on `stall`, the two enables and `ex_bubble`. The random patterns use a small set of register numbers so that matches, register 0 and cleared valid flags occur often.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    OPC_OTHER = 2'd0,
    OPC_LOAD  = 2'd1,
    OPC_STORE = 2'd2,
    OPC_MUL   = 2'd3
  } op_cls_e;
endpackage

// File: rtl/hz_reg_match.sv
module hz_reg_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] a,
  input  logic             a_vld,
  input  logic [REG_W-1:0] b,
  input  logic             b_vld,
  output logic             hit
);
  // register 0 is the hardwired zero: never a real producer
  always_comb hit = a_vld && b_vld && (a != '0) && (a == b);
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src1,
  input  logic             src1_vld,
  input  logic [REG_W-1:0] src2,
  input  logic             src2_vld,
  input  op_cls_e          dop,
  input  logic [REG_W-1:0] xdst,
  input  logic             xdst_vld,
  input  op_cls_e          xop,
  output logic             hz
);
  logic hit1, hit2;

  hz_reg_match #(.REG_W(REG_W)) u_m1 (
    .a(src1), .a_vld(src1_vld), .b(xdst), .b_vld(xdst_vld), .hit(hit1));
  hz_reg_match #(.REG_W(REG_W)) u_m2 (
    .a(src2), .a_vld(src2_vld), .b(xdst), .b_vld(xdst_vld), .hit(hit2));

  // store data operand can be forwarded at the memory stage
  always_comb hz = (xop == OPC_LOAD) && (hit1 || (hit2 && dop != OPC_STORE));
endmodule

// File: rtl/hz_mul_track.sv
module hz_mul_track
  import hz_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter int MUL_STAGES  = 3,
  parameter int CLASH_STAGE = 1
) (
  input  logic [REG_W-1:0]            src1,
  input  logic                        src1_vld,
  input  logic [REG_W-1:0]            src2,
  input  logic                        src2_vld,
  input  logic [REG_W-1:0]            ddst,
  input  logic                        ddst_vld,
  input  op_cls_e                     dop,
  input  logic [REG_W-1:0]            xdst,
  input  logic                        xdst_vld,
  input  op_cls_e                     xop,
  input  logic [MUL_STAGES*REG_W-1:0] mdst,
  input  logic [MUL_STAGES-1:0]       mdst_vld,
  output logic                        hz_operand,
  output logic                        hz_port,
  output logic                        hz_waw
);
  localparam int CLASH_LO = CLASH_STAGE * REG_W;

  logic [MUL_STAGES-1:0] hit_a, hit_b;
  logic                  waw_hit;

  for (genvar k = 0; k < MUL_STAGES; k++) begin : g_stage
    hz_reg_match #(.REG_W(REG_W)) u_ma (
      .a(src1), .a_vld(src1_vld),
      .b(mdst[k*REG_W +: REG_W]), .b_vld(mdst_vld[k]), .hit(hit_a[k]));
    hz_reg_match #(.REG_W(REG_W)) u_mb (
      .a(src2), .a_vld(src2_vld),
      .b(mdst[k*REG_W +: REG_W]), .b_vld(mdst_vld[k]), .hit(hit_b[k]));
  end

  hz_reg_match #(.REG_W(REG_W)) u_waw (
    .a(ddst), .a_vld(ddst_vld), .b(xdst), .b_vld(xdst_vld), .hit(waw_hit));

  logic dec_writes, clash_writes;
  always_comb begin
    dec_writes   = ddst_vld && (ddst != '0);
    clash_writes = mdst_vld[CLASH_STAGE] && (mdst[CLASH_LO +: REG_W] != '0);
    hz_operand   = |(hit_a | hit_b);
    hz_port      = dec_writes && (dop != OPC_MUL) && clash_writes;
    hz_waw       = (xop == OPC_MUL) && waw_hit;
  end
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter int MUL_STAGES  = 3,
  parameter int CLASH_STAGE = 1
) (
  input  logic [REG_W-1:0]            dec_src1,
  input  logic                        dec_src1_vld,
  input  logic [REG_W-1:0]            dec_src2,
  input  logic                        dec_src2_vld,
  input  logic [REG_W-1:0]            dec_dst,
  input  logic                        dec_dst_vld,
  input  logic [1:0]                  dec_op,
  input  logic [REG_W-1:0]            ex_dst,
  input  logic                        ex_dst_vld,
  input  logic [1:0]                  ex_op,
  input  logic [MUL_STAGES*REG_W-1:0] mul_dst,
  input  logic [MUL_STAGES-1:0]       mul_dst_vld,
  output logic                        stall,
  output logic                        pc_we,
  output logic                        dec_latch_we,
  output logic                        ex_bubble,
  output logic                        hz_load_use,
  output logic                        hz_mul_operand,
  output logic                        hz_wb_port,
  output logic                        hz_waw
);
  op_cls_e dop, xop;
  always_comb begin
    dop = op_cls_e'(dec_op);
    xop = op_cls_e'(ex_op);
  end

  hz_load_use #(.REG_W(REG_W)) u_ld (
    .src1(dec_src1), .src1_vld(dec_src1_vld),
    .src2(dec_src2), .src2_vld(dec_src2_vld),
    .dop(dop), .xdst(ex_dst), .xdst_vld(ex_dst_vld), .xop(xop),
    .hz(hz_load_use));

  hz_mul_track #(.REG_W(REG_W), .MUL_STAGES(MUL_STAGES),
                 .CLASH_STAGE(CLASH_STAGE)) u_mul (
    .src1(dec_src1), .src1_vld(dec_src1_vld),
    .src2(dec_src2), .src2_vld(dec_src2_vld),
    .ddst(dec_dst), .ddst_vld(dec_dst_vld), .dop(dop),
    .xdst(ex_dst), .xdst_vld(ex_dst_vld), .xop(xop),
    .mdst(mul_dst), .mdst_vld(mul_dst_vld),
    .hz_operand(hz_mul_operand), .hz_port(hz_wb_port), .hz_waw(hz_waw));

  always_comb begin
    stall        = hz_load_use | hz_mul_operand | hz_wb_port | hz_waw;
    pc_we        = ~stall;
    dec_latch_we = ~stall;
    ex_bubble    = stall;
  end
endmodule

// File: rtl/hazard_stall_unit_chk.sv
module hazard_stall_unit_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] dec_src1,
  input logic             dec_src1_vld,
  input logic [REG_W-1:0] dec_src2,
  input logic [1:0]       dec_op,
  input logic [1:0]       ex_op,
  input logic             stall,
  input logic             pc_we,
  input logic             dec_latch_we,
  input logic             ex_bubble,
  input logic             hz_load_use,
  input logic             hz_mul_operand,
  input logic             hz_wb_port,
  input logic             hz_waw
);
  always_comb begin
    assert_no_loaduse_without_load_R1: assert (ex_op == 2'd1 || !hz_load_use);
    assert_store_src2_exempt_R2: assert (!(dec_op == 2'd2 && !dec_src1_vld) || !hz_load_use);
    assert_mul_no_port_clash_R4: assert (dec_op != 2'd3 || !hz_wb_port);
    assert_waw_needs_mul_R5: assert (ex_op == 2'd3 || !hz_waw);
    assert_controls_agree_R6: assert (pc_we == dec_latch_we && ex_bubble == stall && pc_we != ex_bubble);
    assert_zero_reg_quiet_R8: assert (!(dec_src1 == '0 && dec_src2 == '0) || !(hz_load_use || hz_mul_operand));
    assert_any_term_stalls_R9: assert (!(hz_load_use || hz_mul_operand || hz_wb_port || hz_waw) || stall);
  end
endmodule

bind hazard_stall_unit hazard_stall_unit_chk #(.REG_W(REG_W)) u_chk (
  .dec_src1(dec_src1), .dec_src1_vld(dec_src1_vld), .dec_src2(dec_src2),
  .dec_op(dec_op), .ex_op(ex_op), .stall(stall), .pc_we(pc_we),
  .dec_latch_we(dec_latch_we), .ex_bubble(ex_bubble),
  .hz_load_use(hz_load_use), .hz_mul_operand(hz_mul_operand),
  .hz_wb_port(hz_wb_port), .hz_waw(hz_waw));

// File: tb/hazard_stall_unit_bench.sv
module hazard_stall_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;
  localparam int NS = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [RW-1:0] s1, s2, dd, xd;
  logic s1v, s2v, ddv, xdv;
  logic [1:0] dop, xop;
  logic [NS*RW-1:0] md;
  logic [NS-1:0] mdv;
  logic stall, pc_we, dl_we, bub, t_ld, t_mo, t_wp, t_ww;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  hazard_stall_unit #(.REG_W(RW), .MUL_STAGES(NS), .CLASH_STAGE(1)) u_hazard_stall_unit (
    .dec_src1(s1), .dec_src1_vld(s1v), .dec_src2(s2), .dec_src2_vld(s2v),
    .dec_dst(dd), .dec_dst_vld(ddv), .dec_op(dop),
    .ex_dst(xd), .ex_dst_vld(xdv), .ex_op(xop),
    .mul_dst(md), .mul_dst_vld(mdv),
    .stall(stall), .pc_we(pc_we), .dec_latch_we(dl_we), .ex_bubble(bub),
    .hz_load_use(t_ld), .hz_mul_operand(t_mo), .hz_wb_port(t_wp), .hz_waw(t_ww));

  function automatic bit eq(logic [RW-1:0] a, logic av, logic [RW-1:0] b, logic bv);
    return av && bv && a != 0 && a == b;
  endfunction

  function automatic bit exp_ld();
    return xop == 2'd1 && (eq(s1, s1v, xd, xdv) || (eq(s2, s2v, xd, xdv) && dop != 2'd2));
  endfunction
  function automatic bit exp_mo();
    bit r = 0;
    for (int k = 0; k < NS; k++)
      r |= eq(s1, s1v, md[k*RW +: RW], mdv[k]) | eq(s2, s2v, md[k*RW +: RW], mdv[k]);
    return r;
  endfunction
  function automatic bit exp_wp();
    return ddv && dd != 0 && dop != 2'd3 && mdv[1] && md[RW +: RW] != 0;
  endfunction
  function automatic bit exp_ww();
    return xop == 2'd3 && eq(dd, ddv, xd, xdv);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_all();
    bit l, m, w, x, s;
    l = exp_ld(); m = exp_mo(); w = exp_wp(); x = exp_ww(); s = l | m | w | x;
    chk("R1/R2 load-use", t_ld, l);
    chk("R3 mul operand", t_mo, m);
    chk("R4 write port", t_wp, w);
    chk("R5 waw", t_ww, x);
    chk("R9 stall", stall, s);
    chk("R6 pc_we", pc_we, !s);
    chk("R6 dec_latch_we", dl_we, !s);
    chk("R6 ex_bubble", bub, s);
  endtask

  task automatic idle();
    s1 = 0; s2 = 0; dd = 0; xd = 0; s1v = 0; s2v = 0; ddv = 0; xdv = 0;
    dop = 0; xop = 0; md = 0; mdv = 0;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    idle();
    step();
    chk("R9 idle no stall", stall, 1'b0);
    chk("R6 idle pc_we", pc_we, 1'b1);

    // R1: load then use on first source
    idle(); xop = 2'd1; xd = 5'd3; xdv = 1; s1 = 5'd3; s1v = 1; step();
    chk("R1 load-use src1", t_ld, 1'b1); check_all();
    // R2: store exempt on second source
    idle(); xop = 2'd1; xd = 5'd4; xdv = 1; s2 = 5'd4; s2v = 1; dop = 2'd2; step();
    chk("R2 store src2 exempt", t_ld, 1'b0); check_all();
    dop = 2'd0; step();
    chk("R2 non-store src2", t_ld, 1'b1);
    // R8: register zero and invalid fields
    idle(); xop = 2'd1; xd = 5'd0; xdv = 1; s1 = 5'd0; s1v = 1; step();
    chk("R8 reg0 no match", stall, 1'b0);
    idle(); xop = 2'd1; xd = 5'd6; xdv = 0; s1 = 5'd6; s1v = 1; step();
    chk("R8 invalid dst", stall, 1'b0);
    // R3: stage 3 not observed (only 3 stage ports), stage 2 is
    idle(); s2 = 5'd9; s2v = 1; md[2*RW +: RW] = 5'd9; mdv[2] = 1; step();
    chk("R3 stage2 dep", t_mo, 1'b1);
    // R7: multiply walks P0->P1->P2->out: three stalls then release
    idle(); s1 = 5'd7; s1v = 1;
    for (int c = 0; c < 4; c++) begin
      md = 0; mdv = 0;
      if (c < 3) begin md[c*RW +: RW] = 5'd7; mdv[c] = 1; end
      step();
      chk("R7 consecutive stall", stall, c < 3);
    end
    // R4: write port clash, multiply exempt
    idle(); ddv = 1; dd = 5'd2; md[RW +: RW] = 5'd11; mdv[1] = 1; step();
    chk("R4 port clash", t_wp, 1'b1);
    dop = 2'd3; step();
    chk("R4 mul exempt", t_wp, 1'b0);
    // R5: waw behind multiply
    idle(); xop = 2'd3; xd = 5'd12; xdv = 1; dd = 5'd12; ddv = 1; step();
    chk("R5 waw", t_ww, 1'b1);
    xop = 2'd0; step();
    chk("R5 non-mul no waw", t_ww, 1'b0);

    // random
    void'($urandom(32'd4242));
    for (int i = 0; i < 2000; i++) begin
      s1 = RW'($urandom_range(0, 5)); s2 = RW'($urandom_range(0, 5));
      dd = RW'($urandom_range(0, 5)); xd = RW'($urandom_range(0, 5));
      s1v = 1'($urandom); s2v = 1'($urandom); ddv = 1'($urandom); xdv = 1'($urandom);
      dop = 2'($urandom); xop = 2'($urandom);
      for (int k = 0; k < NS; k++) md[k*RW +: RW] = RW'($urandom_range(0, 5));
      mdv = NS'($urandom);
      step();
      check_all();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule